// File: doc/BRIEF.md
# Multi-Channel Serial Frame Strobe Generator

This block marks word boundaries on four serial input channels (A to D) of a four-channel upconverter. A frame counter advances once per serial bit clock from 0 up to a programmable frame length and then wraps to 0. Each channel has its own programmable 4-bit strobe offset, and a one-bit-clock-wide frame strobe is raised at the frame positions that match that offset. A start pulse marks position 0 of every frame. A data source on a shared time-division bus can use it to open its frame, and the channel offsets then pick out the time slots.

A mode input selects between two packings. In packed mode a complex pair travels as one 32-bit word with one strobe per frame. In unpacked mode each 16-bit half has its own strobe. The offset's lowest bit is then ignored, so each channel sees two strobes 16 bit-times apart. Settings arrive through a simple write port into shadow registers. The frame length, the four offsets and the mode input all take effect together at the next frame wrap, so a running frame is never cut short.

The frame sequencer has two states. ST_HEAD is frame position 0 and is the source of the start pulse. It always moves to ST_BODY on the next clock. ST_BODY covers positions 1 up to the frame length. When the counter equals the active frame length it returns to ST_HEAD, clears the counter and commits the shadow settings; otherwise it stays in ST_BODY and increments.

Top module: `frame_strobe_gen`

## Requirements
- R1: While `rst` is high at a clock edge, all strobes and `start_o` are 0 after that edge. The frame position becomes 0, the frame length 17, every channel offset 1 and the mode packed. The first clock with `rst` low is frame position 0.
- R2: With active frame length L (its lower 4 bits non-zero), a frame lasts L+1 clocks. `start_o` is high for exactly one clock, in the clock after the counter sits at position 0.
- R3: In packed mode a channel with offset d in 0..14 strobes once per frame, in the clock after frame position d. Each output is the registered result of the previous position.
- R4: In packed mode an offset of 15 produces no strobe on that channel.
- R5: In unpacked mode (`pack_mode` = 0) a channel with offset d strobes after positions (d with bit 0 cleared) and that value plus 16. Bit 0 of the offset has no effect.
- R6: No strobe is ever produced for frame positions 32 and above.
- R7: Writes land in shadow registers. Address 0 holds the frame length (all 8 data bits), and addresses 1, 2, 3, 4 hold the offsets of channels A, B, C, D (data bits 3:0). Shadow values become active only at the wrap from position L to 0. A write made on the wrap clock waits for the following wrap.
- R8: `pack_mode` is sampled only on the wrap clock. Changes at any other time have no effect on the strobes.
- R9: Writes to addresses 5, 6 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for the settings port |
| wr_addr | input | 3 | Write address: 0 frame length, 1..4 channel A..D offset |
| wr_data | input | 8 | Write data |
| pack_mode | input | 1 | 1 = packed (one strobe per 32-bit pair), 0 = unpacked (one per 16-bit word) |
| strobe_o | output | 4 | Frame strobes, bit 0 = channel A .. bit 3 = channel D |
| start_o | output | 1 | One-clock pulse at the start of every frame |

## Verification
Every strobe and the start pulse are due one clock after the frame counter holds the position that produces them. A write or a change of `pack_mode` shows up only in the frame that begins after the next wrap, so its effect can be seen between one clock and a full frame length later. The reference model in the bench updates on each rising edge in the same order: first the outputs from the current position, then the wrap with commit of the settings held before that edge, then any write. Outputs are compared against it on every falling edge, so each result is sampled half a cycle after it becomes due, and a write on a wrap clock is deferred exactly as R7 demands.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
    typedef enum logic {
        ST_HEAD = 1'b0,
        ST_BODY = 1'b1
    } frame_state_t;

    localparam int ADDR_FRAME_LEN = 0;
    localparam int ADDR_CH_BASE   = 1;
endpackage

// File: rtl/fsg_frame_fsm.sv
module fsg_frame_fsm
    import fsg_pkg::*;
#(
    parameter int FC_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [FC_W-1:0] frame_len,
    output logic [FC_W-1:0] pos,
    output logic            wrap,
    output logic            start_o
);
    frame_state_t    st_q, st_d;
    logic [FC_W-1:0] cnt_q, cnt_d;
    logic            start_q;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q + 1'b1;
        wrap  = 1'b0;
        unique case (st_q)
            ST_HEAD: st_d = ST_BODY;
            ST_BODY: begin
                if (cnt_q == frame_len) begin
                    st_d  = ST_HEAD;
                    cnt_d = '0;
                    wrap  = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_HEAD;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) start_q <= 1'b0;
        else     start_q <= (st_q == ST_HEAD);
    end

    assign pos     = cnt_q;
    assign start_o = start_q;
endmodule

// File: rtl/fsg_cfg_regs.sv
module fsg_cfg_regs
    import fsg_pkg::*;
#(
    parameter int              NUM_CH  = 4,
    parameter int              FC_W    = 8,
    parameter int              DLY_W   = 4,
    parameter int              AW      = 3,
    parameter logic [FC_W-1:0] FC_RST  = FC_W'(17),
    parameter logic [DLY_W-1:0] DLY_RST = DLY_W'(1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [FC_W-1:0]  wr_data,
    input  logic             mode_in,
    input  logic             commit,
    output logic [FC_W-1:0]  act_len,
    output logic [DLY_W-1:0] act_dly [NUM_CH],
    output logic             act_pk
);
    logic [FC_W-1:0]  sh_len;
    logic [DLY_W-1:0] sh_dly [NUM_CH];

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_len  <= FC_RST;
            act_len <= FC_RST;
            act_pk  <= 1'b1;
            for (int k = 0; k < NUM_CH; k++) begin
                sh_dly[k]  <= DLY_RST;
                act_dly[k] <= DLY_RST;
            end
        end else begin
            if (commit) begin
                act_len <= sh_len;
                act_pk  <= mode_in;
                for (int k = 0; k < NUM_CH; k++) act_dly[k] <= sh_dly[k];
            end
            if (wr_en) begin
                if (wr_addr == AW'(ADDR_FRAME_LEN)) sh_len <= wr_data;
                for (int k = 0; k < NUM_CH; k++) begin
                    if (wr_addr == AW'(ADDR_CH_BASE + k)) sh_dly[k] <= wr_data[DLY_W-1:0];
                end
            end
        end
    end
endmodule

// File: rtl/fsg_slot_match.sv
module fsg_slot_match #(
    parameter int FC_W  = 8,
    parameter int DLY_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [FC_W-1:0]  pos,
    input  logic [DLY_W-1:0] dly,
    input  logic             packed_sel,
    output logic             strobe
);
    localparam int SLOT_W = DLY_W + 1;

    logic             in_win;
    logic [DLY_W-1:0] low;
    logic             hit_pk, hit_up;

    assign low    = pos[DLY_W-1:0];
    assign in_win = (pos[FC_W-1:SLOT_W] == '0);
    assign hit_pk = in_win && !pos[DLY_W] && (low == dly) && (dly != '1);
    assign hit_up = in_win && (low[DLY_W-1:1] == dly[DLY_W-1:1]) && !low[0];

    always_ff @(posedge clk) begin
        if (rst) strobe <= 1'b0;
        else     strobe <= packed_sel ? hit_pk : hit_up;
    end
endmodule

// File: rtl/frame_strobe_gen.sv
module frame_strobe_gen #(
    parameter int NUM_CH  = 4,
    parameter int FC_W    = 8,
    parameter int DLY_W   = 4,
    parameter int AW      = 3,
    parameter int LEN_RST = 17,
    parameter int DLY_RST = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [FC_W-1:0]   wr_data,
    input  logic              pack_mode,
    output logic [NUM_CH-1:0] strobe_o,
    output logic              start_o
);
    logic [FC_W-1:0]  frame_pos;
    logic             frame_wrap;
    logic [FC_W-1:0]  act_len;
    logic [DLY_W-1:0] act_dly [NUM_CH];
    logic             act_pk;

    fsg_frame_fsm #(.FC_W(FC_W)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .frame_len (act_len),
        .pos       (frame_pos),
        .wrap      (frame_wrap),
        .start_o   (start_o)
    );

    fsg_cfg_regs #(
        .NUM_CH  (NUM_CH),
        .FC_W    (FC_W),
        .DLY_W   (DLY_W),
        .AW      (AW),
        .FC_RST  (FC_W'(LEN_RST)),
        .DLY_RST (DLY_W'(DLY_RST))
    ) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .mode_in (pack_mode),
        .commit  (frame_wrap),
        .act_len (act_len),
        .act_dly (act_dly),
        .act_pk  (act_pk)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        fsg_slot_match #(.FC_W(FC_W), .DLY_W(DLY_W)) u_match (
            .clk        (clk),
            .rst        (rst),
            .pos        (frame_pos),
            .dly        (act_dly[g]),
            .packed_sel (act_pk),
            .strobe     (strobe_o[g])
        );
    end
endmodule

// File: rtl/frame_strobe_gen_chk.sv
module frame_strobe_gen_chk #(
    parameter int NUM_CH = 4,
    parameter int FC_W   = 8,
    parameter int DLY_W  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [NUM_CH-1:0] strobe_o,
    input logic              start_o,
    input logic [FC_W-1:0]   frame_pos,
    input logic [FC_W-1:0]   act_len,
    input logic              act_pk
);
    localparam int SLOT_W = DLY_W + 1;

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (strobe_o == '0 && !start_o));

    // R2
    start_single_chk: assert property (@(posedge clk) disable iff (rst)
        start_o |=> !start_o);

    // R6
    window_only_chk: assert property (@(posedge clk) disable iff (rst)
        (strobe_o != '0) |-> ($past(frame_pos[FC_W-1:SLOT_W]) == '0));

    // R7
    len_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_pos != '0) |-> $stable(act_len));

    // R8
    mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_pos != '0) |-> $stable(act_pk));
endmodule

bind frame_strobe_gen frame_strobe_gen_chk #(
    .NUM_CH (NUM_CH),
    .FC_W   (FC_W),
    .DLY_W  (DLY_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .strobe_o  (strobe_o),
    .start_o   (start_o),
    .frame_pos (frame_pos),
    .act_len   (act_len),
    .act_pk    (act_pk)
);

// File: tb/frame_strobe_gen_test.sv
module frame_strobe_gen_test;
    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en;
    logic [2:0] wr_addr;
    logic [7:0] wr_data;
    logic       pack_mode;
    logic [3:0] strobe_o;
    logic       start_o;

    always #4 clk = ~clk;

    frame_strobe_gen uut (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .pack_mode (pack_mode),
        .strobe_o  (strobe_o),
        .start_o   (start_o)
    );

    int    checks = 0;
    int    errors = 0;
    bit    checking = 0;
    bit    done = 0;
    string cur_req = "R1";

    // behavioural reference
    int       m_pos, m_len, m_pk, s_len;
    int       m_dly [4];
    int       s_dly [4];
    logic [3:0] exp_strobe = '0;
    logic       exp_start = 1'b0;

    function automatic bit hit(int p, int d, int pk);
        if (p >= 32) return 1'b0;
        if (pk != 0) return (d != 15) && (p == d);
        return (p % 16) == ((d / 2) * 2);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_pos = 0; m_len = 17; s_len = 17; m_pk = 1;
            for (int k = 0; k < 4; k++) begin m_dly[k] = 1; s_dly[k] = 1; end
            exp_strobe = '0;
            exp_start  = 1'b0;
        end else begin
            exp_start = (m_pos == 0);
            for (int k = 0; k < 4; k++) exp_strobe[k] = hit(m_pos, m_dly[k], m_pk);
            if (m_pos == m_len) begin
                m_pos = 0;
                m_len = s_len;
                m_pk  = pack_mode ? 1 : 0;
                for (int k = 0; k < 4; k++) m_dly[k] = s_dly[k];
            end else begin
                m_pos++;
            end
            if (wr_en) begin
                if (wr_addr == 3'd0) s_len = int'(wr_data);
                else if (wr_addr >= 3'd1 && wr_addr <= 3'd4) s_dly[int'(wr_addr) - 1] = int'(wr_data[3:0]);
            end
        end
    end

    always @(negedge clk) begin
        if (checking) begin
            checks++;
            if (strobe_o !== exp_strobe || start_o !== exp_start) begin
                errors++;
                $display("FAIL %s strobe=%b start=%b expected strobe=%b start=%b",
                         cur_req, strobe_o, start_o, exp_strobe, exp_start);
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = 8'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic summary;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        int unsigned seed = 32'h1234_5678;
        rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0; pack_mode = 1'b1;
        @(posedge clk);
        checking = 1;
        cur_req = "R1";                 // reset state
        idle(3);
        rst = 1'b0;
        cur_req = "R2";                 // default frame, start pulse
        idle(40);
        cur_req = "R3";                 // packed offsets incl. 0 and 14
        wr(0, 40); wr(1, 0); wr(2, 5); wr(3, 9); wr(4, 14);
        idle(100);
        cur_req = "R4";                 // offset 15 silent in packed mode
        wr(2, 15); wr(0, 20);
        idle(60);
        cur_req = "R6";                 // long frame, nothing beyond position 31
        wr(0, 70); wr(1, 3); wr(2, 3); wr(3, 3); wr(4, 3);
        idle(160);
        cur_req = "R5";                 // unpacked: LSB ignored, two strobes
        pack_mode = 1'b0;
        wr(0, 40); wr(1, 4); wr(2, 5); wr(3, 10); wr(4, 15);
        idle(130);
        cur_req = "R8";                 // mode pulse away from wrap
        idle(10);
        pack_mode = 1'b1; idle(3); pack_mode = 1'b0;
        idle(100);
        cur_req = "R9";                 // unused addresses
        wr(5, 8'hff); wr(6, 8'h02); wr(7, 8'h11);
        idle(100);
        cur_req = "R7";                 // writes at arbitrary times incl. wrap clocks
        for (int i = 0; i < 600; i++) begin
            seed = seed * 32'd1103515245 + 32'd12345;
            if (seed[20:18] == 3'd0) begin
                int a = int'(seed[25:23]) % 5;
                int d;
                if (a == 0) begin
                    d = 17 + int'(seed[15:10]) % 40;
                    if ((d % 16) == 0) d++;
                end else begin
                    d = int'(seed[13:10]);
                end
                wr(a, d);
            end else if (seed[20:18] == 3'd1) begin
                pack_mode = seed[9];
                idle(1);
            end else begin
                idle(1);
            end
        end
        idle(120);
        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R2 watchdog cycles=%0d expected<%0d", 150000, 150000);
            summary();
            $finish;
        end
    end
endmodule